// File: doc/BRIEF.md
# Flash Busy Status Generator

This block sits between the storage array of a parallel NOR-style flash device and its data bus. It decides what a read returns while an internal program or erase is under way. When nothing is running, array data goes straight to the bus. While an operation runs, the read word carries three status signals:

- a polling bit on bit 7 that shows whether the operation is a program or an erase;
- an activity bit on bit 6 that changes on every read;
- a suspend bit on bit 2 that changes on every access to a sector whose erase has been suspended.

Beside the data path, the block drives an active-low ready/busy line. It drives that line low only while an operation is running, so several devices can share one wired line.

Program and erase timing and the array itself lie outside the block. They appear as level inputs:

- an operation-active flag and the operation kind;
- the last data word loaded;
- a suspend flag with the suspended sector number;
- the sector being accessed.

Read and program accesses come in as strobes. Only the rising edge of a strobe counts as an access.

Top module: `flash_busy_status_gen`

## Requirements
- R1: When `op_active` is 0 and the access does not hit a suspended sector, `rdata` equals `array_data` on every bit.
- R2: While `op_active` is 1 with `op_kind` = 0 (program) and no suspended-sector hit, bit 7 of `rdata` is the inverse of bit 7 of `load_data`.
- R3: While `op_active` is 1 with `op_kind` = 1 (sector erase), 2 (chip erase) or 3 (treated as erase), and no suspended-sector hit, bit 7 of `rdata` is 0.
- R4: During an operation, every rising edge of `rd_strobe` that does not hit a suspended sector inverts bit 6 for later reads. The first read of an operation sees 0.
- R5: Bit 6 holds its value over cycles with no qualifying read edge. Once `op_active` falls, bit 6 stops changing and reads return array data (R1).
- R6: A suspended-sector hit occurs when `erase_susp` is 1 and `acc_sector` equals `susp_sector`. On a hit, `rdata` is `array_data` with bit 2 replaced by the suspend toggle. Each rising edge of `rd_strobe` or `pg_strobe` during a hit inverts that toggle for later accesses. The first hit access sees 0.
- R7: `rb_oe` is 1 exactly while `op_active` is 1, and `rb_out` is always 0 (open-drain, active low).
- R8: The cycle in which `op_active` rises clears both toggles. Reads in that cycle see 0 on bits 6 and 2, even if earlier reads had left the toggles at 1.
- R9: A read edge in the same cycle as the operation start counts as the first read. It sees 0 on bit 6, and the next read sees 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| op_active | input | 1 | internal program/erase running |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 erase |
| load_data | input | DATA_W | last word loaded for programming |
| erase_susp | input | 1 | a sector erase is suspended |
| susp_sector | input | SECT_W | number of the suspended sector |
| acc_sector | input | SECT_W | sector of the current access |
| rd_strobe | input | 1 | read strobe, rising edge is one read |
| pg_strobe | input | 1 | program strobe, rising edge is one program access |
| array_data | input | DATA_W | word read from the array |
| rdata | output | DATA_W | word returned to the bus |
| rb_oe | output | 1 | enable of the ready/busy driver |
| rb_out | output | 1 | value driven on ready/busy when enabled (always 0) |

## Verification
Two events can land on the same clock edge: an operation start, which clears the toggles, and a read edge, which advances them. The bench raises `rd_strobe` in the same cycle as `op_active`, after earlier reads have left the toggles at 1. It then expects 0 on bit 6 in that cycle and 1 on the following read. It repeats this during a suspend, where a start and a hit access together must show 0 on bit 2. A behavioural model compares the whole word and the busy enable on every cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    OP_PROG       = 2'd0,
    OP_SECT_ERASE = 2'd1,
    OP_CHIP_ERASE = 2'd2,
    OP_ERASE_ALT  = 2'd3
  } op_kind_e;

  // polling value: program shows the inverse of the loaded bit, erase shows 0
  function automatic logic poll_value(op_kind_e kind, logic loaded_bit);
    return (kind == OP_PROG) ? ~loaded_bit : 1'b0;
  endfunction

  function automatic logic next_toggle(logic clr, logic cur, logic adv);
    logic seen;
    seen = clr ? 1'b0 : cur;
    return seen ^ adv;
  endfunction
endpackage

// File: rtl/fbs_rise_det.sv
module fbs_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/fbs_toggle_cell.sv
module fbs_toggle_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic seen
);
  import fbs_pkg::*;
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_toggle(clr, q, adv);
  end

  assign seen = clr ? 1'b0 : q;

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(q));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !adv) |=> (q == 1'b0));
  a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (q != $past(q)));
endmodule

// File: rtl/fbs_status_mux.sv
module fbs_status_mux #(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int ACT_BIT  = 6,
  parameter int SUSP_BIT = 2
) (
  input  logic [DATA_W-1:0] array_data,
  input  logic [DATA_W-1:0] load_data,
  input  logic [1:0]        op_kind,
  input  logic              op_active,
  input  logic              susp_hit,
  input  logic              act_tog,
  input  logic              susp_tog,
  output logic [DATA_W-1:0] rdata
);
  import fbs_pkg::*;

  always_comb begin
    rdata = array_data;
    if (susp_hit) begin
      rdata[SUSP_BIT] = susp_tog;
    end else if (op_active) begin
      rdata[POLL_BIT] = poll_value(op_kind_e'(op_kind), load_data[POLL_BIT]);
      rdata[ACT_BIT]  = act_tog;
    end
  end
endmodule

// File: rtl/flash_busy_status_gen.sv
module flash_busy_status_gen #(
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 5,
  parameter int POLL_BIT = 7,
  parameter int ACT_BIT  = 6,
  parameter int SUSP_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_active,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] load_data,
  input  logic              erase_susp,
  input  logic [SECT_W-1:0] susp_sector,
  input  logic [SECT_W-1:0] acc_sector,
  input  logic              rd_strobe,
  input  logic              pg_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rb_oe,
  output logic              rb_out
);
  localparam int NEDGE = 3;

  // named internal events
  logic [NEDGE-1:0] lvl, rise;
  logic rd_rise, pg_rise, op_start;
  logic susp_hit, act_adv, susp_adv;
  logic act_tog, susp_tog;

  assign lvl = {op_active, pg_strobe, rd_strobe};

  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    fbs_rise_det u_rise (.clk(clk), .rst_n(rst_n), .level(lvl[g]), .rise(rise[g]));
  end

  assign rd_rise  = rise[0];
  assign pg_rise  = rise[1];
  assign op_start = rise[2];

  assign susp_hit = erase_susp && (acc_sector == susp_sector);
  assign act_adv  = op_active && !susp_hit && rd_rise;
  assign susp_adv = susp_hit && (rd_rise || pg_rise);

  fbs_toggle_cell u_act_tog (
    .clk(clk), .rst_n(rst_n), .clr(op_start), .adv(act_adv), .seen(act_tog));
  fbs_toggle_cell u_susp_tog (
    .clk(clk), .rst_n(rst_n), .clr(op_start), .adv(susp_adv), .seen(susp_tog));

  fbs_status_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .ACT_BIT(ACT_BIT),
                   .SUSP_BIT(SUSP_BIT)) u_mux (
    .array_data(array_data), .load_data(load_data), .op_kind(op_kind),
    .op_active(op_active), .susp_hit(susp_hit), .act_tog(act_tog),
    .susp_tog(susp_tog), .rdata(rdata));

  assign rb_oe  = op_active;
  assign rb_out = 1'b0;

  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_active && !erase_susp) |-> (rdata == array_data));
  a_r2_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && !susp_hit && op_kind == 2'd0) |-> (rdata[POLL_BIT] == ~load_data[POLL_BIT]));
  a_r3_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && !susp_hit && op_kind != 2'd0) |-> (rdata[POLL_BIT] == 1'b0));
  a_r9_start_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !susp_hit) |-> (rdata[ACT_BIT] == 1'b0));
endmodule

// File: tb/flash_busy_status_gen_tb_top.sv
module flash_busy_status_gen_tb_top;
  localparam int DW = 16;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_active = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [DW-1:0] load_data = '0;
  logic erase_susp = 1'b0;
  logic [SW-1:0] susp_sector = '0;
  logic [SW-1:0] acc_sector = '0;
  logic rd_strobe = 1'b0;
  logic pg_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rdata;
  logic rb_oe, rb_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_act = 0, m_susp = 0;
  bit p_rd = 0, p_pg = 0, p_op = 0;

  always #10 clk = ~clk;

  flash_busy_status_gen dut_i (
    .clk(clk), .rst_n(rst_n), .op_active(op_active), .op_kind(op_kind),
    .load_data(load_data), .erase_susp(erase_susp), .susp_sector(susp_sector),
    .acc_sector(acc_sector), .rd_strobe(rd_strobe), .pg_strobe(pg_strobe),
    .array_data(array_data), .rdata(rdata), .rb_oe(rb_oe), .rb_out(rb_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit act, bit [1:0] k, bit rd, bit pg,
                     bit sus, bit [SW-1:0] asec, bit [DW-1:0] arr);
    bit start, hit, rrd, rpg;
    int s_act, s_susp;
    logic [DW-1:0] exp;
    op_active = act; op_kind = k; rd_strobe = rd; pg_strobe = pg;
    erase_susp = sus; acc_sector = asec; array_data = arr;
    start = act && !p_op;
    hit = sus && (asec == susp_sector);
    rrd = rd && !p_rd;
    rpg = pg && !p_pg;
    s_act  = start ? 0 : m_act;
    s_susp = start ? 0 : m_susp;
    exp = arr;
    if (hit) exp[2] = s_susp[0];
    else if (act) begin
      exp[7] = (k == 2'd0) ? !load_data[7] : 1'b0;
      exp[6] = s_act[0];
    end
    #2;
    check(tag, 32'(rdata), 32'(exp));
    check({tag, "/R7"}, {30'd0, rb_oe, rb_out}, {30'd0, act, 1'b0});
    @(posedge clk);
    if (act && !hit && rrd) s_act = 1 - s_act;
    if (hit && (rrd || rpg)) s_susp = 1 - s_susp;
    m_act = s_act; m_susp = s_susp;
    p_rd = rd; p_pg = pg; p_op = act;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    susp_sector = 5'd9;
    load_data = 16'h0080;
    repeat (3) @(negedge clk);
    check("R7 reset rb_oe", 32'(rb_oe), 32'd0);
    rst_n = 1'b1;
    // R1 idle passthrough
    cyc("R1", 0, 0, 0, 0, 0, 5'd1, 16'hA5C3);
    cyc("R1", 0, 0, 1, 0, 0, 5'd2, 16'h5A3C);
    cyc("R1", 0, 0, 0, 0, 0, 5'd3, 16'hFFFF);
    // program: R2 polling, R4 toggling reads, R5 hold
    cyc("R2", 1, 0, 0, 0, 0, 5'd1, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      cyc("R4", 1, 0, 1, 0, 0, 5'd1, 16'h1234);
      cyc("R4", 1, 0, 0, 0, 0, 5'd1, 16'h1234);
    end
    cyc("R4", 1, 0, 1, 0, 0, 5'd1, 16'h00FF);
    cyc("R5", 1, 0, 1, 0, 0, 5'd1, 16'h00FF);
    cyc("R5", 1, 0, 1, 0, 0, 5'd1, 16'h00FF);
    load_data = 16'h0000;
    cyc("R2", 1, 0, 0, 0, 0, 5'd1, 16'hFFFF);
    cyc("R5 end", 0, 0, 1, 0, 0, 5'd1, 16'hBEEF);
    cyc("R5 end", 0, 0, 0, 0, 0, 5'd1, 16'hBEEF);
    cyc("R5 end", 0, 0, 1, 0, 0, 5'd1, 16'hBEEF);
    // erase kinds: R3
    for (int k = 1; k < 4; k++) begin
      cyc("R3", 1, 2'(k), 0, 0, 0, 5'd4, 16'hFFFF);
      cyc("R3", 1, 2'(k), 1, 0, 0, 5'd4, 16'hFFFF);
      cyc("R3", 1, 2'(k), 0, 0, 0, 5'd4, 16'hFFFF);
      cyc("R3", 1, 2'(k), 1, 0, 0, 5'd4, 16'hFFFF);
      cyc("R3", 0, 2'(k), 0, 0, 0, 5'd4, 16'h0F0F);
    end
    // leave toggle at 1, then start with a read in the same cycle: R8, R9
    cyc("R9 prep", 1, 0, 1, 0, 0, 5'd4, 16'h0000);
    cyc("R9 prep", 1, 0, 0, 0, 0, 5'd4, 16'h0000);
    cyc("R9 prep", 0, 0, 0, 0, 0, 5'd4, 16'h0000);
    cyc("R9 start+read", 1, 1, 1, 0, 0, 5'd4, 16'h0040);
    cyc("R9 next", 1, 1, 0, 0, 0, 5'd4, 16'h0040);
    cyc("R9 next", 1, 1, 1, 0, 0, 5'd4, 16'h0040);
    cyc("R9", 0, 1, 0, 0, 0, 5'd4, 16'h0040);
    // suspend: R6
    cyc("R6 other", 0, 0, 1, 0, 1, 5'd3, 16'h0004);
    cyc("R6", 0, 0, 0, 0, 1, 5'd9, 16'h0000);
    cyc("R6 read", 0, 0, 1, 0, 1, 5'd9, 16'h0000);
    cyc("R6", 0, 0, 0, 0, 1, 5'd9, 16'h0004);
    cyc("R6 prog", 0, 0, 0, 1, 1, 5'd9, 16'h0004);
    cyc("R6", 0, 0, 0, 0, 1, 5'd9, 16'hFFFB);
    cyc("R6 prog", 0, 0, 0, 1, 1, 5'd9, 16'h0000);
    cyc("R6 other", 0, 0, 0, 0, 1, 5'd8, 16'h0000);
    cyc("R6 other", 0, 0, 1, 0, 1, 5'd8, 16'h1111);
    cyc("R6", 0, 0, 0, 0, 1, 5'd9, 16'h0000);
    // R8: toggle at 1, program start clears it, hit access same cycle
    cyc("R8 start", 1, 0, 1, 0, 1, 5'd9, 16'h0004);
    cyc("R8 after", 1, 0, 0, 0, 1, 5'd9, 16'h0000);
    cyc("R8 other", 1, 0, 1, 0, 1, 5'd2, 16'h0000);
    cyc("R8 other", 1, 0, 0, 0, 1, 5'd2, 16'h0000);
    cyc("R1", 0, 0, 0, 0, 0, 5'd9, 16'hC0DE);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule